// File: doc/BRIEF.md
# UART Interrupt Source Prioritiser

This block merges the four interrupt causes of a character-oriented serial port into a single interrupt line and a byte that software reads to learn which cause it is servicing. The four causes are receive errors, a received character waiting, an emptied transmit holding register and a change on the modem control inputs. Each cause is held in its own small state element. Each one is set by an event from the receiver, the transmitter or the modem logic. Each one is cleared by the register access that services it.

The enable bits come in from the surrounding register file. A cause that is pending but not enabled is kept, and it is not reported. Once it is enabled, it appears in the identification byte without further stimulus. A freeze input, used for debug halts, holds the interrupt line low and leaves the identification byte unchanged.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01 and the interrupt line is low.
- R2: Any bit of the 4-bit error input (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) latches the line-status cause. A line-status read with no new error clears it. When enabled by enable bit 2, it reads as identification byte 0x06 (code 011).
- R3: The received-data cause follows the data-ready input one cycle later. A receive-buffer read in the same cycle forces it clear. When enabled by enable bit 0, it reads as 0x04 (code 010).
- R4: A low-to-high change of the holding-empty input latches the holding-empty cause. A holding-register write clears it, and a write wins over a simultaneous set. When enabled by enable bit 1, it reads as 0x02 (code 001).
- R5: An identification read clears the holding-empty cause only while code 001 is the one being reported. A read while a higher cause is reported leaves it latched.
- R6: A modem-change pulse latches the modem cause. A modem-status read with no new change clears it. When enabled by enable bit 3, it reads as 0x00 (code 000).
- R7: When several enabled causes are pending, the byte reports the highest one in the order line status, received data, holding empty, modem.
- R8: A disabled cause is not reported and does not raise the interrupt line, but stays latched. Enabling it later reports it at once.
- R9: Identification bit 0 is 0 exactly when some enabled cause is pending. Bits 7 to 4 always read 0.
- R10: While freeze is high the interrupt line is low, and the identification byte is unaffected.
- R11: Events and clearing accesses take effect on the identification byte one clock edge after they are sampled. Enable and freeze changes take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en_i | input | 4 | Cause enables: 0 rx data, 1 holding empty, 2 line status, 3 modem |
| rx_err_i | input | 4 | Receive error events: overrun, parity, framing, break |
| rx_ready_i | input | 1 | Data-ready level from receiver |
| tx_empty_i | input | 1 | Holding-register-empty level from transmitter |
| mdm_chg_i | input | 1 | Modem input change event |
| freeze_i | input | 1 | Debug freeze, masks the interrupt line |
| rd_id_i | input | 1 | Identification register read strobe |
| rd_lstat_i | input | 1 | Line status register read strobe |
| rd_rxbuf_i | input | 1 | Receive buffer read strobe |
| wr_txhold_i | input | 1 | Holding register write strobe |
| rd_mstat_i | input | 1 | Modem status register read strobe |
| id_byte_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
Every cause lives in a register, so an event or a clearing access that is driven in one cycle shows on the identification byte one rising edge later. The bench drives on the falling edge, steps one full clock and samples at the next falling edge. Enable and freeze reach the outputs combinationally. For those, the bench changes the input on a falling edge and samples a quarter period later, with no edge in between. This shows that the change itself produced the new value.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NSRC   = 4;
    localparam int NERR   = 4;
    localparam int ID_W   = 8;
    localparam int CODE_W = 3;

    // source index equals its enable bit position
    localparam int SRC_RDA  = 0;
    localparam int SRC_THRE = 1;
    localparam int SRC_LS   = 2;
    localparam int SRC_MS   = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_MS   = 3'b000,
        CODE_THRE = 3'b001,
        CODE_RDA  = 3'b010,
        CODE_LS   = 3'b011
    } irq_code_e;

    typedef struct packed {
        logic ls;
        logic rda;
        logic thre;
        logic ms;
        logic thre_prev;
    } src_state_t;

    // rank 0 is the highest priority
    function automatic int src_of_rank(input int rank);
        case (rank)
            0:       return SRC_LS;
            1:       return SRC_RDA;
            2:       return SRC_THRE;
            default: return SRC_MS;
        endcase
    endfunction

    function automatic irq_code_e code_of_src(input int src);
        case (src)
            SRC_LS:   return CODE_LS;
            SRC_RDA:  return CODE_RDA;
            SRC_THRE: return CODE_THRE;
            default:  return CODE_MS;
        endcase
    endfunction
endpackage

// File: rtl/uirq_sources.sv
module uirq_sources
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NERR-1:0] rx_err_i,
    input  logic            rx_ready_i,
    input  logic            tx_empty_i,
    input  logic            mdm_chg_i,
    input  logic            rd_lstat_i,
    input  logic            rd_rxbuf_i,
    input  logic            wr_txhold_i,
    input  logic            rd_mstat_i,
    input  logic            thre_ack_i,
    output logic [NSRC-1:0] src_o
);
    src_state_t st_d, st_q;
    logic       thre_rise;

    always_comb begin
        st_d      = st_q;
        thre_rise = tx_empty_i && !st_q.thre_prev;

        st_d.thre_prev = tx_empty_i;

        if (|rx_err_i)       st_d.ls = 1'b1;
        else if (rd_lstat_i) st_d.ls = 1'b0;

        st_d.rda = rx_ready_i && !rd_rxbuf_i;

        if (wr_txhold_i)     st_d.thre = 1'b0;
        else if (thre_rise)  st_d.thre = 1'b1;
        else if (thre_ack_i) st_d.thre = 1'b0;

        if (mdm_chg_i)       st_d.ms = 1'b1;
        else if (rd_mstat_i) st_d.ms = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.thre_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        src_o           = '0;
        src_o[SRC_LS]   = st_q.ls;
        src_o[SRC_RDA]  = st_q.rda;
        src_o[SRC_THRE] = st_q.thre;
        src_o[SRC_MS]   = st_q.ms;
    end

    assert_ls_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_err_i) |=> src_o[SRC_LS]);
    assert_ls_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lstat_i && !(|rx_err_i)) |=> !src_o[SRC_LS]);
    assert_rda_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rxbuf_i |=> !src_o[SRC_RDA]);
    assert_thre_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txhold_i |=> !src_o[SRC_THRE]);
    assert_ms_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mstat_i && !mdm_chg_i) |=> !src_o[SRC_MS]);
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0]   active_i,
    output logic              pend_o,
    output logic [CODE_W-1:0] code_o
);
    always_comb begin
        code_o = CODE_MS;
        pend_o = |active_i;
        // scan lowest priority first so higher ranks overwrite
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (active_i[src_of_rank(r)]) code_o = code_of_src(src_of_rank(r));
        end
    end

    always_comb begin
        if (active_i[SRC_LS])
            assert_ls_top_R7: assert (code_o == CODE_LS);
        if (pend_o == 1'b0)
            assert_idle_code_R9: assert (code_o == CODE_MS);
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      irq_en_i,
    input  logic [3:0]      rx_err_i,
    input  logic            rx_ready_i,
    input  logic            tx_empty_i,
    input  logic            mdm_chg_i,
    input  logic            freeze_i,
    input  logic            rd_id_i,
    input  logic            rd_lstat_i,
    input  logic            rd_rxbuf_i,
    input  logic            wr_txhold_i,
    input  logic            rd_mstat_i,
    output logic [7:0]      id_byte_o,
    output logic            irq_o
);
    logic [NSRC-1:0]   src_q;
    logic [NSRC-1:0]   active_d;
    logic              pend_d;
    logic [CODE_W-1:0] code_d;
    logic              thre_ack_d;

    uirq_sources u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_err_i    (rx_err_i),
        .rx_ready_i  (rx_ready_i),
        .tx_empty_i  (tx_empty_i),
        .mdm_chg_i   (mdm_chg_i),
        .rd_lstat_i  (rd_lstat_i),
        .rd_rxbuf_i  (rd_rxbuf_i),
        .wr_txhold_i (wr_txhold_i),
        .rd_mstat_i  (rd_mstat_i),
        .thre_ack_i  (thre_ack_d),
        .src_o       (src_q)
    );

    assign active_d = src_q & irq_en_i;

    uirq_prio u_prio (
        .active_i (active_d),
        .pend_o   (pend_d),
        .code_o   (code_d)
    );

    always_comb begin
        thre_ack_d = rd_id_i && pend_d && (code_d == CODE_THRE);
        id_byte_o  = '0;
        id_byte_o[CODE_W:1] = code_d;
        id_byte_o[0]        = !pend_d;
        irq_o      = pend_d && !freeze_i;
    end

    assert_freeze_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |-> !irq_o);
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_byte_o[7:4] == 4'h0);
    assert_irq_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !id_byte_o[0]);
    assert_thre_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_ack_d && !wr_txhold_i && tx_empty_i && $past(tx_empty_i)) |=> !src_q[SRC_THRE]);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_en_i = '0;
    logic [3:0] rx_err_i = '0;
    logic       rx_ready_i = 1'b0;
    logic       tx_empty_i = 1'b1;
    logic       mdm_chg_i = 1'b0;
    logic       freeze_i = 1'b0;
    logic       rd_id_i = 1'b0;
    logic       rd_lstat_i = 1'b0;
    logic       rd_rxbuf_i = 1'b0;
    logic       wr_txhold_i = 1'b0;
    logic       rd_mstat_i = 1'b0;
    logic [7:0] id_byte_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1.25;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_en_i = '0; rx_err_i = '0; rx_ready_i = 1'b0; tx_empty_i = 1'b1;
        mdm_chg_i = 1'b0; freeze_i = 1'b0; rd_id_i = 1'b0; rd_lstat_i = 1'b0;
        rd_rxbuf_i = 1'b0; wr_txhold_i = 1'b0; rd_mstat_i = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        irq_en_i = 4'hF;
        settle();
        chk("R1 id", id_byte_o, 8'h01);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_line();
        do_reset();
        irq_en_i = 4'b0100;
        for (int b = 0; b < 4; b++) begin
            rx_err_i = 4'b0001 << b;
            step();
            rx_err_i = '0;
            chk("R2 set by error bit", id_byte_o, 8'h06);
            chk("R11 irq after edge", {7'b0, irq_o}, 8'h01);
            rd_lstat_i = 1'b1;
            step();
            rd_lstat_i = 1'b0;
            chk("R2 clear on read", id_byte_o, 8'h01);
        end
    endtask

    task automatic t_rda();
        do_reset();
        irq_en_i = 4'b0001;
        rx_ready_i = 1'b1;
        settle();
        chk("R11 not before edge", id_byte_o, 8'h01);
        step();
        chk("R3 follows ready", id_byte_o, 8'h04);
        rd_rxbuf_i = 1'b1;
        step();
        chk("R3 read clears", id_byte_o, 8'h01);
        rd_rxbuf_i = 1'b0;
        rx_ready_i = 1'b0;
        step();
        chk("R3 stays clear", id_byte_o, 8'h01);
    endtask

    task automatic t_thre();
        do_reset();
        irq_en_i = 4'b0010;
        settle();
        chk("R4 no cause at reset", id_byte_o, 8'h01);
        tx_empty_i = 1'b0; step();
        tx_empty_i = 1'b1; step();
        chk("R4 set on empty rise", id_byte_o, 8'h02);
        step();
        chk("R4 stays latched", id_byte_o, 8'h02);
        wr_txhold_i = 1'b1; step();
        wr_txhold_i = 1'b0;
        chk("R4 write clears", id_byte_o, 8'h01);
        tx_empty_i = 1'b0; step();
        tx_empty_i = 1'b1; wr_txhold_i = 1'b1; step();
        wr_txhold_i = 1'b0;
        chk("R4 write wins over set", id_byte_o, 8'h01);
    endtask

    task automatic t_thre_id();
        do_reset();
        irq_en_i = 4'b0110;
        tx_empty_i = 1'b0; step();
        tx_empty_i = 1'b1; rx_err_i = 4'b0010; step();
        rx_err_i = '0;
        chk("R5 line status reported", id_byte_o, 8'h06);
        rd_id_i = 1'b1; step();
        rd_id_i = 1'b0;
        rd_lstat_i = 1'b1; step();
        rd_lstat_i = 1'b0;
        chk("R5 id read under higher cause keeps thre", id_byte_o, 8'h02);
        rd_id_i = 1'b1; step();
        rd_id_i = 1'b0;
        chk("R5 id read clears thre", id_byte_o, 8'h01);
    endtask

    task automatic t_modem();
        do_reset();
        irq_en_i = 4'b1000;
        mdm_chg_i = 1'b1; step();
        mdm_chg_i = 1'b0;
        chk("R6 modem pending", id_byte_o, 8'h00);
        chk("R9 irq with code 000", {7'b0, irq_o}, 8'h01);
        rd_mstat_i = 1'b1; step();
        rd_mstat_i = 1'b0;
        chk("R6 status read clears", id_byte_o, 8'h01);
    endtask

    task automatic t_prio();
        do_reset();
        irq_en_i = 4'hF;
        mdm_chg_i = 1'b1; step();
        mdm_chg_i = 1'b0;
        tx_empty_i = 1'b0; step();
        tx_empty_i = 1'b1; step();
        chk("R7 thre over modem", id_byte_o, 8'h02);
        rx_ready_i = 1'b1; step();
        chk("R7 rx data over thre", id_byte_o, 8'h04);
        rx_err_i = 4'b1000; step();
        rx_err_i = '0;
        chk("R7 line status over all", id_byte_o, 8'h06);
        rd_lstat_i = 1'b1; step();
        rd_lstat_i = 1'b0;
        chk("R7 back to rx data", id_byte_o, 8'h04);
        rx_ready_i = 1'b0; rd_rxbuf_i = 1'b1; step();
        rd_rxbuf_i = 1'b0;
        wr_txhold_i = 1'b1; step();
        wr_txhold_i = 1'b0;
        chk("R7 modem last", id_byte_o, 8'h00);
    endtask

    task automatic t_mask();
        do_reset();
        irq_en_i = 4'b0000;
        mdm_chg_i = 1'b1; step();
        mdm_chg_i = 1'b0;
        chk("R8 disabled not reported", id_byte_o, 8'h01);
        chk("R8 disabled no irq", {7'b0, irq_o}, 8'h00);
        step();
        irq_en_i = 4'b1000;
        settle();
        chk("R8 enable reports latched", id_byte_o, 8'h00);
        chk("R11 enable same cycle irq", {7'b0, irq_o}, 8'h01);
    endtask

    task automatic t_freeze();
        do_reset();
        irq_en_i = 4'b0100;
        rx_err_i = 4'b0100; step();
        rx_err_i = '0;
        freeze_i = 1'b1;
        settle();
        chk("R10 freeze masks irq", {7'b0, irq_o}, 8'h00);
        chk("R10 byte unaffected", id_byte_o, 8'h06);
        step();
        freeze_i = 1'b0;
        settle();
        chk("R10 release restores irq", {7'b0, irq_o}, 8'h01);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_line();
        t_rda();
        t_thre();
        t_thre_id();
        t_modem();
        t_prio();
        t_mask();
        t_freeze();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule